// File: doc/BRIEF.md
# Charge Share Polarity Sequencer

This block orders what a column driver does on each display line. When the line strobe drops from high to low, the columns first go through a charge-share interval. In that interval every column is joined to the others, so the positive and negative columns settle toward mid-range without drawing supply current. When the interval ends, the columns are driven with their converted values until the next strobe. A register count sets the length of the interval, which in silicon would come from an external RC network. A count of zero leaves the interval out.

The block also selects which reference bank feeds the odd columns and which feeds the even columns. A polarity input sets this choice. The block samples polarity only at the strobe's falling edge, so the selection never changes in the middle of a line. A falling edge that arrives during a charge-share interval starts the interval again with a freshly sampled length.

All inputs are synchronous to `clk`. The reset is asynchronous and active low.

Top module: `charge_share_seq`

## Requirements
- R1: While reset is held and after its release, `share_o` and `drive_valid_o` are 0. Until the first strobe fall, `odd_upper_o` is 1 and `even_upper_o` is 0.
- R2: When a clock edge samples `load_i` low and the previous edge sampled it high, this is a strobe fall. If the sampled `share_len_i` N is nonzero, `share_o` is 1 for exactly N cycles, starting one cycle after the fall is presented.
- R3: After the charge-share interval, `drive_valid_o` is 1 and stays 1 until the next strobe fall. `share_o` and `drive_valid_o` are never both 1.
- R4: A strobe fall with `share_len_i` equal to 0 sets `drive_valid_o` on the next cycle, and `share_o` stays 0.
- R5: A strobe fall with `pol_i` = 0 gives `odd_upper_o` = 1 and `even_upper_o` = 0. A value of 1 means the upper bank and 0 means the lower bank.
- R6: A strobe fall with `pol_i` = 1 gives `odd_upper_o` = 0 and `even_upper_o` = 1.
- R7: A change on `pol_i` away from a strobe fall leaves both bank selects unchanged.
- R8: A strobe fall during a charge-share interval restarts the interval. `share_o` then stays 1 for the newly sampled length.
- R9: A rising `load_i`, or a `load_i` held steady, does not change the phase outputs.
- R10: `share_len_i` is sampled only at a strobe fall. Changing it during the interval does not change that interval's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Line strobe; its falling edge starts a line |
| pol_i | input | 1 | Polarity that selects the reference banks |
| share_len_i | input | LEN_W | Charge-share length in cycles; 0 skips the interval |
| share_o | output | 1 | Columns are in charge-share mode |
| drive_valid_o | output | 1 | Columns drive their converted values |
| odd_upper_o | output | 1 | Odd columns use the upper bank (1) or the lower bank (0) |
| even_upper_o | output | 1 | Even columns use the upper bank (1) or the lower bank (0) |

## Verification
A strobe fall acts at the clock edge that first samples `load_i` low. At that edge the phase, the remaining count and both bank selects update together, so every result is due one cycle after the fall is presented. The bench drives inputs on the falling clock edge and reads outputs on the next falling edge, half a cycle after each register has updated. It counts the charge-share length as the number of consecutive samples with `share_o` high and compares that count with the sampled length.

// File: rtl/csps_pkg.sv
package csps_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SHARE = 2'd1,
    PH_DRIVE = 2'd2
  } phase_t;

  // A strobe fall: high on the previous sample, low now.
  function automatic logic strobe_fell(input logic prev_s, input logic now_s);
    return prev_s & ~now_s;
  endfunction

  // Phase entered when a strobe fall arrives.
  function automatic phase_t phase_at_strobe(input logic len_is_zero);
    return len_is_zero ? PH_DRIVE : PH_SHARE;
  endfunction

  // Odd-column bank select for a polarity value (1 = upper bank).
  function automatic logic odd_bank_for(input logic pol);
    return ~pol;
  endfunction

endpackage

// File: rtl/csps_load_edge.sv
module csps_load_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic load_fall_o
);
  import csps_pkg::*;

  logic load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_q <= 1'b0;
    else        load_q <= load_i;
  end

  assign load_fall_o = strobe_fell(load_q, load_i);

  // R9: a fall is reported only after a high sample followed by a low one.
  assert_fall_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_fall_o |-> (!load_i && $past(load_i)));

endmodule

// File: rtl/csps_share_timer.sv
module csps_share_timer #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_fall_i,
  input  logic [LEN_W-1:0] share_len_i,
  output logic             share_o,
  output logic             drive_valid_o
);
  import csps_pkg::*;

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  phase_t           phase;
  logic [LEN_W-1:0] remain;
  logic             len_zero;
  logic             share_last;

  assign len_zero   = (share_len_i == '0);
  assign share_last = (phase == PH_SHARE) && (remain <= ONE) && !load_fall_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      remain <= '0;
    end else if (load_fall_i) begin
      phase  <= phase_at_strobe(len_zero);
      remain <= share_len_i;
    end else if (phase == PH_SHARE) begin
      if (remain <= ONE) phase <= PH_DRIVE;
      if (remain != '0)  remain <= remain - ONE;
    end
  end

  assign share_o       = (phase == PH_SHARE);
  assign drive_valid_o = (phase == PH_DRIVE);

  assert_start_share_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fall_i && share_len_i != '0) |=> share_o);

  assert_share_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (share_o && remain > ONE && !load_fall_i) |=> share_o);

  assert_share_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    share_last |=> drive_valid_o);

  assert_drive_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_valid_o && !load_fall_i) |=> drive_valid_o);

  assert_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(share_o && drive_valid_o));

  assert_zero_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fall_i && share_len_i == '0) |=> (drive_valid_o && !share_o));

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_fall_i |=> remain == $past(share_len_i));

  assert_count_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (share_o && !load_fall_i) |=> remain == $past(remain) - ONE);

endmodule

// File: rtl/csps_bank_sel.sv
module csps_bank_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic load_fall_i,
  input  logic pol_i,
  output logic odd_upper_o,
  output logic even_upper_o
);
  import csps_pkg::*;

  logic odd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           odd_q <= 1'b1;
    else if (load_fall_i) odd_q <= odd_bank_for(pol_i);
  end

  assign odd_upper_o  = odd_q;
  assign even_upper_o = ~odd_q;

  // R5 and R6: the selects follow the polarity sampled at the fall.
  assert_bank_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_fall_i |=> (odd_upper_o == !$past(pol_i) && even_upper_o == $past(pol_i)));

  assert_bank_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_fall_i |=> $stable(odd_upper_o));

  assert_bank_split_R6: assert property (@(posedge clk) disable iff (!rst_n)
    odd_upper_o != even_upper_o);

endmodule

// File: rtl/charge_share_seq.sv
module charge_share_seq #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             pol_i,
  input  logic [LEN_W-1:0] share_len_i,
  output logic             share_o,
  output logic             drive_valid_o,
  output logic             odd_upper_o,
  output logic             even_upper_o
);

  logic load_fall;

  csps_load_edge u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .load_fall_o (load_fall)
  );

  csps_share_timer #(.LEN_W(LEN_W)) u_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_fall_i   (load_fall),
    .share_len_i   (share_len_i),
    .share_o       (share_o),
    .drive_valid_o (drive_valid_o)
  );

  csps_bank_sel u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_fall_i  (load_fall),
    .pol_i        (pol_i),
    .odd_upper_o  (odd_upper_o),
    .even_upper_o (even_upper_o)
  );

  // R1: the phase outputs stay idle after reset until a strobe fall.
  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!share_o && !drive_valid_o && !load_fall) |=> !share_o);

endmodule

// File: tb/charge_share_seq_test.sv
module charge_share_seq_test;

  localparam int LEN_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             load_i = 1'b0;
  logic             pol_i = 1'b0;
  logic [LEN_W-1:0] share_len_i = '0;
  logic             share_o, drive_valid_o, odd_upper_o, even_upper_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  charge_share_seq #(.LEN_W(LEN_W)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_i        (load_i),
    .pol_i         (pol_i),
    .share_len_i   (share_len_i),
    .share_o       (share_o),
    .drive_valid_o (drive_valid_o),
    .odd_upper_o   (odd_upper_o),
    .even_upper_o  (even_upper_o)
  );

  // {expected odd select, polarity, length}
  localparam logic [9:0] VEC [0:5] = '{
    {1'b1, 1'b0, 8'd4},
    {1'b0, 1'b1, 8'd1},
    {1'b1, 1'b0, 8'd7},
    {1'b0, 1'b1, 8'd0},
    {1'b0, 1'b1, 8'd12},
    {1'b1, 1'b0, 8'd2}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  int overlap = 0;

  // Count consecutive samples with share_o high.
  task automatic count_share(output int n);
    n = 0;
    while (share_o && n < 400) begin
      if (drive_valid_o) overlap++;
      n++;
      step();
    end
  endtask

  // Presents a strobe fall and leaves time on the sample after it.
  task automatic strobe(input logic pol, input logic [LEN_W-1:0] len);
    load_i = 1'b1;
    step();
    load_i = 1'b0;
    pol_i = pol;
    share_len_i = len;
    step();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    step();
    check("R1 share in reset", int'(share_o), 0);
    check("R1 drive in reset", int'(drive_valid_o), 0);
    step();
    rst_n = 1'b1;
    step();
    step();
    check("R1 share after reset", int'(share_o), 0);
    check("R1 drive after reset", int'(drive_valid_o), 0);
    check("R1 odd select after reset", int'(odd_upper_o), 1);
    check("R1 even select after reset", int'(even_upper_o), 0);

    // R9: a high load_i while idle does nothing.
    load_i = 1'b1;
    step(); step();
    check("R9 rise while idle", int'(share_o | drive_valid_o), 0);

    // Table of lines.
    for (int i = 0; i < 6; i++) begin
      strobe(VEC[i][8], VEC[i][7:0]);
      check("R5 R6 odd select", int'(odd_upper_o), int'(VEC[i][9]));
      check("R5 R6 even select", int'(even_upper_o), int'(!VEC[i][9]));
      if (VEC[i][7:0] == 0) check("R4 no share on zero", int'(share_o), 0);
      count_share(n);
      check("R2 share length", n, int'(VEC[i][7:0]));
      check("R3 drive after share", int'(drive_valid_o), 1);
      step();
      check("R3 drive holds", int'(drive_valid_o), 1);
    end
    check("R3 no overlap", overlap, 0);

    // R7: polarity toggles during drive do not move the selects.
    pol_i = 1'b0;
    step();
    pol_i = 1'b1;
    step();
    check("R7 odd select held", int'(odd_upper_o), 1);
    check("R7 even select held", int'(even_upper_o), 0);

    // R9: raising and holding load_i during drive changes nothing.
    load_i = 1'b1;
    step(); step(); step();
    check("R9 drive kept on rise", int'(drive_valid_o), 1);
    check("R9 no share on rise", int'(share_o), 0);
    load_i = 1'b0;
    pol_i = 1'b0;
    step();

    // R8: a fall during share restarts with the new length.
    strobe(1'b1, 8'd10);
    step(); step(); step();
    check("R8 still sharing", int'(share_o), 1);
    strobe(1'b0, 8'd3);
    count_share(n);
    check("R8 restarted length", n, 3);
    check("R8 select from second fall", int'(odd_upper_o), 1);

    // R10: a length change during share is ignored.
    strobe(1'b0, 8'd9);
    share_len_i = 8'd2;
    count_share(n);
    check("R10 length held", n, 9);
    check("R10 drive after share", int'(drive_valid_o), 1);

    // R4: a zero length during share goes straight to drive.
    strobe(1'b1, 8'd6);
    strobe(1'b1, 8'd0);
    check("R4 zero length restart", int'(drive_valid_o), 1);
    check("R4 no share", int'(share_o), 0);

    // R1: reset mid-line returns to idle.
    strobe(1'b1, 8'd5);
    rst_n = 1'b0;
    step();
    check("R1 reset clears share", int'(share_o), 0);
    check("R1 reset restores odd select", int'(odd_upper_o), 1);
    rst_n = 1'b1;
    step();
    check("R1 idle after second reset", int'(drive_valid_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule